// File: doc/BRIEF.md
# Shared Interrupt Source Router

This block holds the state of every external interrupt source of a multi-core interrupt controller. Each source has a pending flag, an enable flag, a target pin number and an optional target core. From these it builds one registered, level-sensitive request line for each (core, pin) pair. A line is high while at least one enabled, pending source is routed to it. A per-core local compare request, with its own mask and pin choice, arrives on input ports and is ORed into the same lines.

Software reaches the block through a simple register port with one address, a write strobe, a read strobe and 32-bit data. Through it, software reads the pending and enable flags as bitmaps. It enables and disables sources by writing set and clear bitmaps. It programs each source's pin and core routing. One "edge" register forces a single source's pending flag high or low. Hardware sources are level inputs: when a level changes, the pending flag follows it.

Top module: `irq_route_shared`

## Requirements
- R1: When the sampled level of `src_in[s]` differs from its value in the previous cycle, the pending flag of source s takes the new level. A level change wins over a software edge write to the same source in the same cycle.
- R2: A write to the set-enable bitmap (0x060–0x07F) enables every source whose data bit is 1. A write to the clear-enable bitmap (0x040–0x05F) disables every source whose data bit is 1. Sources whose data bit is 0 keep their enable.
- R3: Reads of the pending bitmap (0x000–0x01F) and the enable bitmap (0x020–0x03F) return 32 flags. Data bit i belongs to source 8×(address byte offset)+i. Read data appears on `reg_rdata` one cycle after the read strobe and holds until the next read.
- R4: The pin-map register of source s lies at 0x400+4s. Only bit 31 (route flag) and bits 5:0 (pin) are stored; all other bits read 0. A write whose pin field is not below N_PIN changes nothing.
- R5: The core-map register of source s lies at 0x2000+32s. A write stores the index of the lowest set data bit, and a write of 0 clears the target. A read returns 1 shifted left by the stored core, or 0 when no core is set. A write whose lowest set bit is not below N_CORE changes nothing.
- R6: A write to the edge register (0x080) selects a source with data bits 30:0. Bit 31 = 1 makes that source pending, and bit 31 = 0 clears its pending flag. An index not below N_SRC is ignored.
- R7: `irq_out[c*N_PIN+p]` is the OR of pending & enabled over all sources that target core c and pin p. It changes one cycle after the state it depends on.
- R8: Local request c drives `irq_out[c*N_PIN+p]` while `lcl_req[c]` and `lcl_mask[c]` are both 1 and `lcl_pin[6c+5:6c]` equals p. The line follows these inputs one cycle later.
- R9: A pending source that is disabled drives no output. Enabling it again raises its line on the next cycle.
- R10: After reset every source is disabled and not pending, its pin map reads 0x8000_0000, its core map reads 0, and all outputs are low.
- R11: A read of an unmapped address, or of a bitmap window that runs past the last source, returns 0. A write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | N_SRC | External source levels |
| lcl_req | input | N_CORE | Local compare request per core |
| lcl_mask | input | N_CORE | Local compare mask per core |
| lcl_pin | input | 6*N_CORE | Local compare target pin per core |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 14 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| irq_out | output | N_CORE*N_PIN | Per-core, per-pin request lines |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle. They also assume that source inputs do not change in a cycle where an edge-register property is checked, since a level change legally overrides the software write. The stimulus drives strobes one at a time on the falling edge. It holds `src_in` constant outside the level-following test, and it holds the local request inputs quiet except in the local-request test.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int ADDR_W = 14;
    localparam int DATA_W = 32;
    localparam int PIN_FW = 6;

    localparam logic [ADDR_W-1:0] A_PEND  = 14'h0000;
    localparam logic [ADDR_W-1:0] A_EN    = 14'h0020;
    localparam logic [ADDR_W-1:0] A_CLR   = 14'h0040;
    localparam logic [ADDR_W-1:0] A_SET   = 14'h0060;
    localparam logic [ADDR_W-1:0] A_EDGE  = 14'h0080;
    localparam logic [ADDR_W-1:0] A_PMAP  = 14'h0400;
    localparam logic [ADDR_W-1:0] A_CMAP  = 14'h2000;

    typedef enum logic [2:0] {
        RG_NONE, RG_PEND, RG_EN, RG_CLR, RG_SET, RG_EDGE, RG_PMAP, RG_CMAP
    } region_e;

    function automatic region_e region_of(input logic [ADDR_W-1:0] a);
        region_e r;
        if (a < A_EN)                       r = RG_PEND;
        else if (a < A_CLR)                 r = RG_EN;
        else if (a < A_SET)                 r = RG_CLR;
        else if (a < A_EDGE)                r = RG_SET;
        else if (a == A_EDGE)               r = RG_EDGE;
        else if (a[13:10] == 4'b0001)       r = RG_PMAP;
        else if (a[13])                     r = RG_CMAP;
        else                                r = RG_NONE;
        return r;
    endfunction

    function automatic logic [5:0] lowest_one(input logic [DATA_W-1:0] v);
        logic [5:0] r;
        r = 6'd0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (v[i]) r = 6'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_src_state.sv
module irq_src_state
    import irq_route_pkg::*;
#(
    parameter int N_SRC  = 64,
    parameter int N_CORE = 4,
    parameter int N_PIN  = 6,
    localparam int CORE_W = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SRC-1:0]              src_in,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [N_SRC-1:0]              pend_o,
    output logic [N_SRC-1:0]              en_o,
    output logic [N_SRC-1:0]              pflag_o,
    output logic [N_SRC-1:0][PIN_FW-1:0]  pin_o,
    output logic [N_SRC-1:0]              cvld_o,
    output logic [N_SRC-1:0][CORE_W-1:0]  core_o
);

    typedef struct packed {
        logic [N_SRC-1:0]             pend;
        logic [N_SRC-1:0]             en;
        logic [N_SRC-1:0]             seen;
        logic [N_SRC-1:0]             pflag;
        logic [N_SRC-1:0][PIN_FW-1:0] pin;
        logic [N_SRC-1:0]             cvld;
        logic [N_SRC-1:0][CORE_W-1:0] core;
    } state_t;

    state_t st_d, st_q;

    region_e             rg;
    int                  boff;
    logic                fits;
    logic [N_SRC+31:0]   wide;
    logic [N_SRC-1:0]    bmap;
    int                  midx;
    int                  cidx;
    int                  eidx;
    logic [5:0]          low;

    always_comb begin
        st_d      = st_q;
        st_d.seen = src_in;
        rg        = region_of(reg_addr);
        boff      = int'(reg_addr[4:0]) * 8;
        fits      = (boff + 32) <= N_SRC;
        wide      = {{N_SRC{1'b0}}, reg_wdata} << boff;
        bmap      = wide[N_SRC-1:0];
        midx      = int'(reg_addr[9:2]);
        cidx      = int'(reg_addr[12:5]);
        eidx      = int'(reg_wdata[7:0]);
        low       = lowest_one(reg_wdata);

        if (reg_wr) begin
            unique case (rg)
                RG_CLR: if (fits) st_d.en = st_q.en & ~bmap;
                RG_SET: if (fits) st_d.en = st_q.en | bmap;
                RG_EDGE: begin
                    if ({1'b0, reg_wdata[30:0]} < 32'(N_SRC))
                        st_d.pend[eidx] = reg_wdata[31];
                end
                RG_PMAP: begin
                    if (midx < N_SRC && int'(reg_wdata[5:0]) < N_PIN) begin
                        st_d.pflag[midx] = reg_wdata[31];
                        st_d.pin[midx]   = reg_wdata[5:0];
                    end
                end
                RG_CMAP: begin
                    if (cidx < N_SRC) begin
                        if (reg_wdata == '0) begin
                            st_d.cvld[cidx] = 1'b0;
                        end else if (int'(low) < N_CORE) begin
                            st_d.cvld[cidx] = 1'b1;
                            st_d.core[cidx] = CORE_W'(low);
                        end
                    end
                end
                default: ;
            endcase
        end

        for (int s = 0; s < N_SRC; s++) begin
            if (src_in[s] != st_q.seen[s]) st_d.pend[s] = src_in[s];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend  <= '0;
            st_q.en    <= '0;
            st_q.seen  <= '0;
            st_q.pflag <= '1;
            st_q.pin   <= '0;
            st_q.cvld  <= '0;
            st_q.core  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o  = st_q.pend;
    assign en_o    = st_q.en;
    assign pflag_o = st_q.pflag;
    assign pin_o   = st_q.pin;
    assign cvld_o  = st_q.cvld;
    assign core_o  = st_q.core;

    if (N_SRC >= 32) begin : g_clr_chk
        p_clear_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == A_CLR && reg_wdata[0]) |=> !en_o[0]);
    end

    p_pin_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && region_of(reg_addr) == RG_PMAP && int'(reg_wdata[5:0]) >= N_PIN)
        |=> ($stable(pin_o) && $stable(pflag_o)));

    p_edge_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_EDGE && {1'b0, reg_wdata[30:0]} >= 32'(N_SRC)
         && src_in == st_q.seen) |=> $stable(pend_o));

    p_hole_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && region_of(reg_addr) == RG_NONE)
        |=> ($stable(en_o) && $stable(pin_o) && $stable(cvld_o)));

endmodule

// File: rtl/irq_pin_fold.sv
module irq_pin_fold
    import irq_route_pkg::*;
#(
    parameter int N_SRC  = 64,
    parameter int N_CORE = 4,
    parameter int N_PIN  = 6,
    localparam int CORE_W = (N_CORE > 1) ? $clog2(N_CORE) : 1,
    localparam int N_OUT  = N_CORE * N_PIN
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SRC-1:0]              pend_i,
    input  logic [N_SRC-1:0]              en_i,
    input  logic [N_SRC-1:0][PIN_FW-1:0]  pin_i,
    input  logic [N_SRC-1:0]              cvld_i,
    input  logic [N_SRC-1:0][CORE_W-1:0]  core_i,
    input  logic [N_CORE-1:0]             lcl_req_i,
    input  logic [N_CORE-1:0]             lcl_mask_i,
    input  logic [N_CORE*PIN_FW-1:0]      lcl_pin_i,
    output logic [N_OUT-1:0]              irq_o
);

    typedef struct packed {
        logic [N_OUT-1:0] irq;
    } fold_t;

    fold_t fd_d, fd_q;
    logic  acc;

    always_comb begin
        fd_d = fd_q;
        acc  = 1'b0;
        for (int c = 0; c < N_CORE; c++) begin
            for (int p = 0; p < N_PIN; p++) begin
                acc = lcl_req_i[c] & lcl_mask_i[c]
                    & (lcl_pin_i[c*PIN_FW +: PIN_FW] == PIN_FW'(p));
                for (int s = 0; s < N_SRC; s++) begin
                    acc = acc | (pend_i[s] & en_i[s] & cvld_i[s]
                               & (core_i[s] == CORE_W'(c))
                               & (pin_i[s] == PIN_FW'(p)));
                end
                fd_d.irq[c*N_PIN + p] = acc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fd_q <= '0;
        else        fd_q <= fd_d;
    end

    assign irq_o = fd_q.irq;

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|(pend_i & en_i)) && !(|(lcl_req_i & lcl_mask_i))) |=> (irq_o == '0));

    p_local0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_req_i[0] && lcl_mask_i[0] && lcl_pin_i[PIN_FW-1:0] == '0) |=> irq_o[0]);

endmodule

// File: rtl/irq_reg_read.sv
module irq_reg_read
    import irq_route_pkg::*;
#(
    parameter int N_SRC  = 64,
    parameter int N_CORE = 4,
    localparam int CORE_W = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_rd,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [N_SRC-1:0]              pend_i,
    input  logic [N_SRC-1:0]              en_i,
    input  logic [N_SRC-1:0]              pflag_i,
    input  logic [N_SRC-1:0][PIN_FW-1:0]  pin_i,
    input  logic [N_SRC-1:0]              cvld_i,
    input  logic [N_SRC-1:0][CORE_W-1:0]  core_i,
    output logic [DATA_W-1:0]             rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t               rd_d, rd_q;
    region_e           rg;
    int                boff;
    logic              fits;
    logic [N_SRC+31:0] wide;
    int                midx;
    int                cidx;

    always_comb begin
        rd_d = rd_q;
        rg   = region_of(reg_addr);
        boff = int'(reg_addr[4:0]) * 8;
        fits = (boff + 32) <= N_SRC;
        midx = int'(reg_addr[9:2]);
        cidx = int'(reg_addr[12:5]);
        wide = '0;
        if (reg_rd) begin
            rd_d.rdata = '0;
            unique case (rg)
                RG_PEND: begin
                    wide = {32'b0, pend_i} >> boff;
                    if (fits) rd_d.rdata = wide[31:0];
                end
                RG_EN: begin
                    wide = {32'b0, en_i} >> boff;
                    if (fits) rd_d.rdata = wide[31:0];
                end
                RG_PMAP: begin
                    if (midx < N_SRC)
                        rd_d.rdata = {pflag_i[midx], 25'b0, pin_i[midx]};
                end
                RG_CMAP: begin
                    if (cidx < N_SRC && cvld_i[cidx])
                        rd_d.rdata = 32'(1) << core_i[cidx];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata_o = rd_q.rdata;

    p_core_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && region_of(reg_addr) == RG_CMAP) |=> $onehot0(rdata_o));

    p_hole_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && region_of(reg_addr) == RG_NONE) |=> (rdata_o == '0));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(rdata_o));

endmodule

// File: rtl/irq_route_shared.sv
module irq_route_shared
    import irq_route_pkg::*;
#(
    parameter int N_SRC  = 64,
    parameter int N_CORE = 4,
    parameter int N_PIN  = 6,
    localparam int CORE_W = (N_CORE > 1) ? $clog2(N_CORE) : 1,
    localparam int N_OUT  = N_CORE * N_PIN
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_SRC-1:0]            src_in,
    input  logic [N_CORE-1:0]           lcl_req,
    input  logic [N_CORE-1:0]           lcl_mask,
    input  logic [N_CORE*PIN_FW-1:0]    lcl_pin,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    output logic [N_OUT-1:0]            irq_out
);

    initial begin
        assert (N_SRC >= 8 && N_SRC <= 256 && (N_SRC % 8) == 0)
            else $error("source count must be a multiple of 8 in 8..256");
        assert (N_CORE >= 1 && N_CORE <= 32)
            else $error("core count must be in 1..32");
        assert (N_PIN >= 1 && N_PIN <= 64)
            else $error("pin count must be in 1..64");
    end

    logic [N_SRC-1:0]             pend_w;
    logic [N_SRC-1:0]             en_w;
    logic [N_SRC-1:0]             pflag_w;
    logic [N_SRC-1:0][PIN_FW-1:0] pin_w;
    logic [N_SRC-1:0]             cvld_w;
    logic [N_SRC-1:0][CORE_W-1:0] core_w;

    irq_src_state #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_PIN(N_PIN)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend_o    (pend_w),
        .en_o      (en_w),
        .pflag_o   (pflag_w),
        .pin_o     (pin_w),
        .cvld_o    (cvld_w),
        .core_o    (core_w)
    );

    irq_pin_fold #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_PIN(N_PIN)) u_fold (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend_w),
        .en_i       (en_w),
        .pin_i      (pin_w),
        .cvld_i     (cvld_w),
        .core_i     (core_w),
        .lcl_req_i  (lcl_req),
        .lcl_mask_i (lcl_mask),
        .lcl_pin_i  (lcl_pin),
        .irq_o      (irq_out)
    );

    irq_reg_read #(.N_SRC(N_SRC), .N_CORE(N_CORE)) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .pend_i   (pend_w),
        .en_i     (en_w),
        .pflag_i  (pflag_w),
        .pin_i    (pin_w),
        .cvld_i   (cvld_w),
        .core_i   (core_w),
        .rdata_o  (reg_rdata)
    );

endmodule

// File: tb/irq_route_shared_tb.sv
module irq_route_shared_tb;

    localparam int N_SRC  = 64;
    localparam int N_CORE = 4;
    localparam int N_PIN  = 6;
    localparam int N_OUT  = N_CORE * N_PIN;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N_SRC-1:0]     src_in = '0;
    logic [N_CORE-1:0]    lcl_req = '0;
    logic [N_CORE-1:0]    lcl_mask = '0;
    logic [N_CORE*6-1:0]  lcl_pin = '0;
    logic                 reg_wr = 1'b0;
    logic                 reg_rd = 1'b0;
    logic [13:0]          reg_addr = '0;
    logic [31:0]          reg_wdata = '0;
    logic [31:0]          reg_rdata;
    logic [N_OUT-1:0]     irq_out;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    irq_route_shared #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_PIN(N_PIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .lcl_req(lcl_req),
        .lcl_mask(lcl_mask), .lcl_pin(lcl_pin), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    typedef struct packed {
        logic        rd;
        logic [13:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 14'h0000, 32'h0,          32'h0,          8'd10}, // R10 pending clear
        '{1'b1, 14'h0020, 32'h0,          32'h0,          8'd10}, // R10 enable clear
        '{1'b1, 14'h0400, 32'h0,          32'h8000_0000,  8'd10}, // R10 pin map default
        '{1'b1, 14'h2000, 32'h0,          32'h0,          8'd10}, // R10 no core
        '{1'b0, 14'h0060, 32'h0000_00F5,  32'h0,          8'd2},
        '{1'b1, 14'h0020, 32'h0,          32'h0000_00F5,  8'd2},  // R2 set
        '{1'b0, 14'h0040, 32'h0000_0011,  32'h0,          8'd2},
        '{1'b1, 14'h0020, 32'h0,          32'h0000_00E4,  8'd2},  // R2 clear, zeros keep
        '{1'b0, 14'h0064, 32'h8000_0001,  32'h0,          8'd3},
        '{1'b1, 14'h0024, 32'h0,          32'h8000_0001,  8'd3},  // R3 offset 4
        '{1'b1, 14'h0021, 32'h0,          32'h0100_0000,  8'd3},  // R3 offset 1
        '{1'b1, 14'h0025, 32'h0,          32'h0,          8'd11}, // R11 window past end
        '{1'b0, 14'h040C, 32'hFFFF_FF03,  32'h0,          8'd4},
        '{1'b1, 14'h040C, 32'h0,          32'h8000_0003,  8'd4},  // R4 stored fields
        '{1'b0, 14'h040C, 32'h0000_0007,  32'h0,          8'd4},
        '{1'b1, 14'h040C, 32'h0,          32'h8000_0003,  8'd4},  // R4 reject pin 7
        '{1'b0, 14'h2060, 32'h0000_000C,  32'h0,          8'd5},
        '{1'b1, 14'h2060, 32'h0,          32'h0000_0004,  8'd5},  // R5 lowest bit
        '{1'b0, 14'h2060, 32'h0000_0010,  32'h0,          8'd5},
        '{1'b1, 14'h2060, 32'h0,          32'h0000_0004,  8'd5},  // R5 reject core 4
        '{1'b0, 14'h2060, 32'h0,          32'h0,          8'd5},
        '{1'b1, 14'h2060, 32'h0,          32'h0,          8'd5},  // R5 zero clears
        '{1'b0, 14'h2060, 32'h0000_0008,  32'h0,          8'd5},
        '{1'b1, 14'h2060, 32'h0,          32'h0000_0008,  8'd5},  // R5 core 3
        '{1'b0, 14'h0080, 32'h8000_0003,  32'h0,          8'd6},
        '{1'b1, 14'h0000, 32'h0,          32'h0000_0008,  8'd6},  // R6 force pending
        '{1'b0, 14'h0080, 32'h8000_0040,  32'h0,          8'd6},
        '{1'b1, 14'h0000, 32'h0,          32'h0000_0008,  8'd6},  // R6 index 64 ignored
        '{1'b0, 14'h0100, 32'hFFFF_FFFF,  32'h0,          8'd11},
        '{1'b1, 14'h0100, 32'h0,          32'h0,          8'd11}, // R11 hole reads 0
        '{1'b1, 14'h0020, 32'h0,          32'h0000_00E4,  8'd11}, // R11 no side effect
        '{1'b0, 14'h0080, 32'h0000_0003,  32'h0,          8'd6},
        '{1'b1, 14'h0000, 32'h0,          32'h0,          8'd6},  // R6 clear pending
        '{1'b0, 14'h0080, 32'h8000_0003,  32'h0,          8'd6},
        '{1'b1, 14'h0000, 32'h0,          32'h0000_0008,  8'd6}   // R6 set again
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(32'(irq_out), 32'h0, "R10 outputs after reset");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) begin
                rd(VEC[i].addr, v);
                check(v, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
            end else begin
                wr(VEC[i].addr, VEC[i].data);
            end
        end

        // R9: source 3 pending, disabled, routed core 3 pin 3
        repeat (2) @(negedge clk);
        check(32'(irq_out), 32'h0, "R9 disabled pending is silent");
        wr(14'h0060, 32'h0000_0008);
        check(32'(irq_out), 32'h0, "R7 output not yet updated");
        @(negedge clk);
        check(32'(irq_out), 32'h1 << 21, "R7 R9 line core3 pin3");
        wr(14'h0040, 32'h0000_0008);
        @(negedge clk);
        check(32'(irq_out), 32'h0, "R9 disable drops line");

        // R1: source 5 (enabled) routed to core 0, pin 0
        wr(14'h20A0, 32'h0000_0001);
        @(negedge clk); src_in[5] = 1'b1;
        repeat (2) @(negedge clk);
        check(32'(irq_out), 32'h1, "R1 R7 level raises core0 pin0");
        rd(14'h0000, v);
        check(v, 32'h0000_0028, "R1 pending follows high level");
        src_in[5] = 1'b0;
        repeat (2) @(negedge clk);
        check(32'(irq_out), 32'h0, "R1 level low drops line");
        rd(14'h0000, v);
        check(v, 32'h0000_0008, "R1 pending follows low level");

        // R8: local request of core 1
        lcl_pin[11:6] = 6'd2; lcl_req[1] = 1'b1; lcl_mask[1] = 1'b1;
        repeat (2) @(negedge clk);
        check(32'(irq_out), 32'h1 << 8, "R8 local core1 pin2");
        lcl_pin[11:6] = 6'd3;
        repeat (2) @(negedge clk);
        check(32'(irq_out), 32'h1 << 9, "R8 local core1 pin3");
        lcl_mask[1] = 1'b0;
        repeat (2) @(negedge clk);
        check(32'(irq_out), 32'h0, "R8 masked local silent");
        lcl_req[1] = 1'b0;

        // R10: reset mid-run
        wr(14'h0060, 32'h0000_0008);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(32'(irq_out), 32'h0, "R10 outputs cleared by reset");
        rd(14'h0020, v);
        check(v, 32'h0, "R10 enables cleared by reset");
        rd(14'h0000, v);
        check(v, 32'h0, "R10 pending cleared by reset");
        rd(14'h2060, v);
        check(v, 32'h0, "R10 core map cleared by reset");

        finish_run();
    end

endmodule